// File: doc/BRIEF.md
# Bridge Short-Circuit Fault Manager

This block watches the switch nodes of a three-phase half-bridge for shorted power transistors and decides how the gate drive reacts. For every phase it receives two raw comparator results: the node sitting under the high reference, and the node sitting over the low reference. It also receives the high-side and low-side gate commands. When a node disagrees with the transistor that is commanded on, and that disagreement lasts for a programmable time, the block raises a qualified fault flag.

A 3-bit reaction code chooses what happens next. The options are to report only, to switch off just the faulty phase, to switch off every phase together with the relay drivers, or to do that and also stop the charge pump. Each of these shutdown choices comes in a recovering form and in a form that holds off until cleared.

An active-low diagnostic output stays low until software clears the sticky per-flag status bits with a write strobe. A newly written reaction code is held back until no fault and no status remain.

Top module: `sc_fault_mgr`

## Requirements
- R1: For phase p, a low-side-short condition is `hi_cmd[p]` high together with `node_below_hi[p]` high. A high-side-short condition is `lo_cmd[p]` high together with `node_above_lo[p]` high.
- R2: A flag asserts only once its condition has been sampled true on N consecutive clock edges. N is 4 × 2^(`cfg_filt`+1) clocks: 8, 16, 32 or 64 for `cfg_filt` = 0, 1, 2, 3, which is 2, 4, 8 or 16 µs at 4 clocks per µs. One edge without the condition restarts the count, and the flag drops on the first edge where the condition is false. The filter setting resets to 0 and takes effect on the edge after `cfg_stb`.
- R3: Code 000 leaves every driver output equal to its command, but the flag still sets status and pulls `diag_n` low.
- R4: Code 001 forces low both `hi_out[p]` and `lo_out[p]` of a phase that has a live flag. The phase recovers on the edge where the flag drops.
- R5: Code 010 is the reset value. It forces low both drivers of a phase that has a live flag or a set status bit, and keeps them low until that phase's status is cleared. The other phases follow their commands.
- R6: Code 011 forces all high, low and relay outputs low while any flag is live. Code 100 keeps them low while any flag or status bit is set.
- R7: Codes 101 and 110 act as 011 and 100 respectively, and also drive `cp_en` low. Every other code keeps `cp_en` high.
- R8: Code 111 stops detection: no flag asserts and no status bit sets.
- R9: `diag_n` is low whenever any flag or any status bit is set, so it stays low after the fault releases until the status is cleared.
- R10: A `clr_stb` pulse clears the status bits selected by `clr_mask`. A bit whose flag is live at that edge stays set.
- R11: While `drv_off_ext` is high, every filter count is held at zero, so no flag can assert. Detection resumes when the input falls.
- R12: `cfg_stb` writes a pending code. The pending code becomes active only on an edge where no flag is live and no status bit is set.
- R13: Flag and status bit p (p = 0..2) is the low-side short of phase p. Bit 3+p is the high-side short of phase p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 4 cycles per µs nominal |
| rst | input | 1 | Synchronous active-high reset |
| hi_cmd | input | 3 | High-side gate commands per phase |
| lo_cmd | input | 3 | Low-side gate commands per phase |
| rel_cmd | input | 5 | Supply and motor relay driver commands |
| node_below_hi | input | 3 | Raw comparator: node below high reference |
| node_above_lo | input | 3 | Raw comparator: node above low reference |
| drv_off_ext | input | 1 | Drivers off due to another fault |
| cfg_stb | input | 1 | Configuration write strobe |
| cfg_code | input | 3 | Reaction code to write |
| cfg_filt | input | 2 | Filter time select to write |
| clr_stb | input | 1 | Status clear strobe |
| clr_mask | input | 6 | Status bits to clear |
| hi_out | output | 3 | Gated high-side drive |
| lo_out | output | 3 | Gated low-side drive |
| rel_out | output | 5 | Gated relay drive |
| cp_en | output | 1 | Charge pump enable |
| diag_n | output | 1 | Active-low diagnostic |
| sc_flag | output | 6 | Live qualified fault flags |
| sc_status | output | 6 | Sticky status bits |

## Verification
The assertions assume that the clear and configuration strobes are synchronous pulses, and that a rising `diag_n` can only follow a clear. In other words, they rely on nothing other than `clr_stb` removing status. The stimulus changes every input half a cycle away from the sampling edge. It raises each comparator only in combination with the matching gate command when a fault is intended. Reaction codes are rewritten only while idle, except in the one scenario that deliberately writes a code during a live fault to exercise the deferred switch-over.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [2:0] {
        RX_DIAG_ONLY  = 3'd0,
        RX_PH_REC     = 3'd1,
        RX_PH_HOLD    = 3'd2,
        RX_ALL_REC    = 3'd3,
        RX_ALL_HOLD   = 3'd4,
        RX_ALLCP_REC  = 3'd5,
        RX_ALLCP_HOLD = 3'd6,
        RX_NONE       = 3'd7
    } react_e;

    typedef struct packed {
        logic per_phase;
        logic all_phase;
        logic pump;
        logic hold;
    } react_t;

    function automatic react_t decode_react(react_e c);
        react_t r;
        r = '0;
        case (c)
            RX_PH_REC:     r.per_phase = 1'b1;
            RX_PH_HOLD:    begin r.per_phase = 1'b1; r.hold = 1'b1; end
            RX_ALL_REC:    r.all_phase = 1'b1;
            RX_ALL_HOLD:   begin r.all_phase = 1'b1; r.hold = 1'b1; end
            RX_ALLCP_REC:  begin r.all_phase = 1'b1; r.pump = 1'b1; end
            RX_ALLCP_HOLD: begin r.all_phase = 1'b1; r.pump = 1'b1; r.hold = 1'b1; end
            default:       r = '0;
        endcase
        return r;
    endfunction

    function automatic int unsigned filt_limit(int unsigned cyc_per_us, logic [1:0] sel);
        return cyc_per_us * (32'd2 << sel);
    endfunction

endpackage

// File: rtl/sc_qual_filter.sv
module sc_qual_filter #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cond_i,
    input  logic [CW-1:0] lim_i,
    output logic          flag_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !cond_i) begin
            cnt_q <= '0;
        end else if (cnt_q < lim_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign flag_o = (cnt_q >= lim_i);

    assert_flag_needs_cond_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> $past(cond_i));

endmodule

// File: rtl/sc_status_ctl.sv
module sc_status_ctl
    import sc_pkg::*;
#(
    parameter int NFLAG = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] flag_i,
    input  logic             clr_stb_i,
    input  logic [NFLAG-1:0] clr_mask_i,
    input  logic             cfg_stb_i,
    input  logic [2:0]       cfg_code_i,
    input  logic [1:0]       cfg_filt_i,
    output logic [NFLAG-1:0] status_o,
    output react_e           act_o,
    output logic [1:0]       filt_o
);
    logic [NFLAG-1:0] st_q;
    react_e           act_q, pend_q;
    logic [1:0]       filt_q;
    logic             idle;

    assign idle = !(|flag_i) && !(|st_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            act_q  <= RX_PH_HOLD;
            pend_q <= RX_PH_HOLD;
            filt_q <= 2'd0;
        end else begin
            st_q <= flag_i | (st_q & ~({NFLAG{clr_stb_i}} & clr_mask_i));
            if (idle) begin
                act_q <= pend_q;
            end
            if (cfg_stb_i) begin
                pend_q <= react_e'(cfg_code_i);
                filt_q <= cfg_filt_i;
            end
        end
    end

    assign status_o = st_q;
    assign act_o    = act_q;
    assign filt_o   = filt_q;

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_chk
            assert_clear_blocked_R10: assert property (@(posedge clk) disable iff (rst)
                flag_i[i] |=> status_o[i]);
        end
    endgenerate

    assert_code_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        ((|flag_i) || (|status_o)) |=> (act_o == $past(act_o)));

endmodule

// File: rtl/sc_reaction.sv
module sc_reaction
    import sc_pkg::*;
#(
    parameter int NPH  = 3,
    parameter int NREL = 5
) (
    input  react_e             act_i,
    input  logic [2*NPH-1:0]   flag_i,
    input  logic [2*NPH-1:0]   status_i,
    input  logic [NPH-1:0]     hi_cmd_i,
    input  logic [NPH-1:0]     lo_cmd_i,
    input  logic [NREL-1:0]    rel_cmd_i,
    output logic [NPH-1:0]     hi_o,
    output logic [NPH-1:0]     lo_o,
    output logic [NREL-1:0]    rel_o,
    output logic               cp_en_o,
    output logic               diag_n_o
);
    react_t         rx;
    logic [NPH-1:0] hit_live, hit_held, hit, ph_off;
    logic           any_hit, all_off;

    assign rx = decode_react(act_i);

    generate
        for (genvar p = 0; p < NPH; p++) begin : g_ph
            assign hit_live[p] = flag_i[p] | flag_i[NPH+p];
            assign hit_held[p] = hit_live[p] | status_i[p] | status_i[NPH+p];
            assign hit[p]      = rx.hold ? hit_held[p] : hit_live[p];
            assign ph_off[p]   = rx.per_phase & hit[p];
        end
    endgenerate

    assign any_hit  = |hit;
    assign all_off  = rx.all_phase & any_hit;
    assign hi_o     = hi_cmd_i & ~ph_off & {NPH{~all_off}};
    assign lo_o     = lo_cmd_i & ~ph_off & {NPH{~all_off}};
    assign rel_o    = rel_cmd_i & {NREL{~all_off}};
    assign cp_en_o  = ~(rx.pump & any_hit);
    assign diag_n_o = ~((|flag_i) | (|status_i));

endmodule

// File: rtl/sc_fault_mgr.sv
module sc_fault_mgr
    import sc_pkg::*;
#(
    parameter int NPH        = 3,
    parameter int NREL       = 5,
    parameter int CYC_PER_US = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NPH-1:0]      hi_cmd,
    input  logic [NPH-1:0]      lo_cmd,
    input  logic [NREL-1:0]     rel_cmd,
    input  logic [NPH-1:0]      node_below_hi,
    input  logic [NPH-1:0]      node_above_lo,
    input  logic                drv_off_ext,
    input  logic                cfg_stb,
    input  logic [2:0]          cfg_code,
    input  logic [1:0]          cfg_filt,
    input  logic                clr_stb,
    input  logic [2*NPH-1:0]    clr_mask,
    output logic [NPH-1:0]      hi_out,
    output logic [NPH-1:0]      lo_out,
    output logic [NREL-1:0]     rel_out,
    output logic                cp_en,
    output logic                diag_n,
    output logic [2*NPH-1:0]    sc_flag,
    output logic [2*NPH-1:0]    sc_status
);
    localparam int NFLAG = 2 * NPH;
    localparam int CW    = $clog2(CYC_PER_US * 16 + 1);

    react_e           act;
    logic [1:0]       filt;
    logic [CW-1:0]    lim;
    logic             det_en;
    logic [NFLAG-1:0] cond;

    assign lim    = CW'(filt_limit(CYC_PER_US, filt));
    assign det_en = !drv_off_ext && (act != RX_NONE);

    generate
        for (genvar p = 0; p < NPH; p++) begin : g_cond
            assign cond[p]     = det_en & hi_cmd[p] & node_below_hi[p];
            assign cond[NPH+p] = det_en & lo_cmd[p] & node_above_lo[p];
        end
        for (genvar i = 0; i < NFLAG; i++) begin : g_filt
            sc_qual_filter #(.CW(CW)) u_filt (
                .clk    (clk),
                .rst    (rst),
                .cond_i (cond[i]),
                .lim_i  (lim),
                .flag_o (sc_flag[i])
            );
        end
    endgenerate

    sc_status_ctl #(.NFLAG(NFLAG)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .flag_i     (sc_flag),
        .clr_stb_i  (clr_stb),
        .clr_mask_i (clr_mask),
        .cfg_stb_i  (cfg_stb),
        .cfg_code_i (cfg_code),
        .cfg_filt_i (cfg_filt),
        .status_o   (sc_status),
        .act_o      (act),
        .filt_o     (filt)
    );

    sc_reaction #(.NPH(NPH), .NREL(NREL)) u_react (
        .act_i     (act),
        .flag_i    (sc_flag),
        .status_i  (sc_status),
        .hi_cmd_i  (hi_cmd),
        .lo_cmd_i  (lo_cmd),
        .rel_cmd_i (rel_cmd),
        .hi_o      (hi_out),
        .lo_o      (lo_out),
        .rel_o     (rel_out),
        .cp_en_o   (cp_en),
        .diag_n_o  (diag_n)
    );

    assert_none_no_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (act == RX_NONE) |=> (sc_flag == '0));

    assert_diag_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(diag_n) |-> $past(clr_stb));

    assert_pump_cause_R7: assert property (@(posedge clk) disable iff (rst)
        !cp_en |-> ((|sc_flag) || (|sc_status)));

    generate
        for (genvar p = 0; p < NPH; p++) begin : g_hold_chk
            assert_hold_phase_R5: assert property (@(posedge clk) disable iff (rst)
                ((act == RX_PH_HOLD) && (sc_status[p] || sc_status[NPH+p]))
                    |-> (!hi_out[p] && !lo_out[p]));
        end
    endgenerate

endmodule

// File: tb/tb_sc_fault_mgr.sv
module tb_sc_fault_mgr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hi_cmd = 3'b101, lo_cmd = 3'b010;
    logic [4:0] rel_cmd = 5'h1f;
    logic [2:0] node_below_hi = '0, node_above_lo = '0;
    logic       drv_off_ext = 1'b0;
    logic       cfg_stb = 1'b0;
    logic [2:0] cfg_code = 3'd2;
    logic [1:0] cfg_filt = 2'd0;
    logic       clr_stb = 1'b0;
    logic [5:0] clr_mask = '0;
    logic [2:0] hi_out, lo_out;
    logic [4:0] rel_out;
    logic       cp_en, diag_n;
    logic [5:0] sc_flag, sc_status;

    sc_fault_mgr dut (
        .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .rel_cmd(rel_cmd),
        .node_below_hi(node_below_hi), .node_above_lo(node_above_lo),
        .drv_off_ext(drv_off_ext), .cfg_stb(cfg_stb), .cfg_code(cfg_code),
        .cfg_filt(cfg_filt), .clr_stb(clr_stb), .clr_mask(clr_mask),
        .hi_out(hi_out), .lo_out(lo_out), .rel_out(rel_out), .cp_en(cp_en),
        .diag_n(diag_n), .sc_flag(sc_flag), .sc_status(sc_status)
    );

    always #10 clk = ~clk;

    int    compared = 0, mismatched = 0;
    bit    running = 0, done = 0;
    string cur_req = "R5";

    // behavioural reference state
    int m_cnt[6];
    bit m_st[6];
    int m_act, m_pend, m_filt;

    function automatic int lim_of(int sel);
        int us;
        us = 2 * (1 << sel);
        return us * 4;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_cnt[i]) begin m_cnt[i] = 0; m_st[i] = 0; end
            m_act = 2; m_pend = 2; m_filt = 0;
        end else begin
            bit fl[6];
            bit busy;
            bit c;
            busy = 0;
            for (int i = 0; i < 6; i++) begin
                fl[i] = (m_cnt[i] >= lim_of(m_filt));
                if (fl[i] || m_st[i]) busy = 1;
            end
            for (int i = 0; i < 6; i++) begin
                if (i < 3) c = hi_cmd[i] && node_below_hi[i];
                else       c = lo_cmd[i-3] && node_above_lo[i-3];
                if (drv_off_ext || m_act == 7) c = 0;
                if (!c) m_cnt[i] = 0;
                else if (m_cnt[i] < lim_of(m_filt)) m_cnt[i]++;
                if (fl[i]) m_st[i] = 1;
                else if (clr_stb && clr_mask[i]) m_st[i] = 0;
            end
            if (!busy) m_act = m_pend;
            if (cfg_stb) begin m_pend = cfg_code; m_filt = cfg_filt; end
        end
    end

    function automatic logic [24:0] model_out();
        logic [5:0] fl, st;
        logic [2:0] hit, phoff, hi, lo;
        logic [4:0] rel;
        bit hold, any_hit, alloff, cpoff;
        for (int i = 0; i < 6; i++) begin
            fl[i] = (m_cnt[i] >= lim_of(m_filt));
            st[i] = m_st[i];
        end
        hold = (m_act == 2 || m_act == 4 || m_act == 6);
        for (int p = 0; p < 3; p++) begin
            hit[p] = fl[p] || fl[p+3];
            if (hold) hit[p] = hit[p] || st[p] || st[p+3];
        end
        any_hit = (hit != 0);
        phoff   = (m_act == 1 || m_act == 2) ? hit : 3'b000;
        alloff  = any_hit && (m_act >= 3 && m_act <= 6);
        cpoff   = any_hit && (m_act == 5 || m_act == 6);
        hi  = alloff ? 3'b000 : (hi_cmd & ~phoff);
        lo  = alloff ? 3'b000 : (lo_cmd & ~phoff);
        rel = alloff ? 5'h00 : rel_cmd;
        return {hi, lo, rel, ~cpoff, ~((fl != 0) || (st != 0)), st, fl};
    endfunction

    always @(negedge clk) begin
        if (running && !done) begin
            logic [24:0] got, exp;
            got = {hi_out, lo_out, rel_out, cp_en, diag_n, sc_status, sc_flag};
            exp = model_out();
            compared++;
            if (got !== exp) begin
                mismatched++;
                $display("FAIL %s cycle compare: actual %h expected %h at %0t", cur_req, got, exp, $time);
            end
        end
    end

    task automatic chk(bit ok, string req, int act_v, int exp_v);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act_v, exp_v, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic cfg(int code, int filt);
        cfg_stb = 1; cfg_code = 3'(code); cfg_filt = 2'(filt);
        cyc(1);
        cfg_stb = 0;
        cyc(1);
    endtask

    task automatic clear_all();
        clr_stb = 1; clr_mask = 6'h3f;
        cyc(1);
        clr_stb = 0; clr_mask = 6'h00;
        cyc(1);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        cyc(3);
        rst = 0;
        running = 1;
        cyc(1);
        @(negedge clk);
        chk(sc_status == 0 && diag_n && cp_en && hi_out == 3'b101, "R5 reset state", {sc_status, diag_n, cp_en}, 6'h00 << 2 | 3);

        // R1, R2, R13, R5, R9: low-side short on phase 0
        cur_req = "R2";
        cyc(1); node_below_hi[0] = 1;
        cyc(7); @(negedge clk); chk(sc_flag == 0, "R2 no flag after 7 edges", sc_flag, 0);
        cyc(1); node_below_hi[0] = 0;
        cyc(1); node_below_hi[0] = 1;
        cyc(7); @(negedge clk); chk(sc_flag == 0, "R2 gap restarts count", sc_flag, 0);
        cyc(1); @(negedge clk);
        chk(sc_flag == 6'b000001, "R13 low-side short phase 0 is bit 0 (R1)", sc_flag, 1);
        cur_req = "R5";
        chk(hi_out == 3'b100, "R5 detected phase off only", hi_out, 3'b100);
        cyc(1); node_below_hi[0] = 0;
        cyc(1); @(negedge clk);
        chk(sc_flag == 0 && hi_out == 3'b100, "R5 held off after release", hi_out, 3'b100);
        chk(diag_n == 0, "R9 diag held low after release", diag_n, 0);
        cyc(1); clear_all(); @(negedge clk);
        chk(hi_out == 3'b101 && diag_n == 1, "R5 recovery after clear", {hi_out, diag_n}, 4'b1011);

        // R10: clear ignored while live
        cur_req = "R10";
        cyc(1); node_below_hi[2] = 1;
        cyc(8); clr_stb = 1; clr_mask = 6'h3f;
        cyc(1); clr_stb = 0; clr_mask = 0;
        @(negedge clk); chk(sc_status[2] == 1, "R10 status kept while fault live", sc_status, 6'b000100);
        cyc(1); node_below_hi[2] = 0;
        cyc(1); clear_all();
        @(negedge clk); chk(sc_status == 0, "R10 clear after release", sc_status, 0);

        // R4: per-phase recoverable, high-side short on phase 2
        cur_req = "R4";
        cyc(1); cfg(1, 0);
        lo_cmd = 3'b110; node_above_lo[2] = 1;
        cyc(8); @(negedge clk);
        chk(sc_flag == 6'b100000, "R13 high-side short phase 2 is bit 5 (R1)", sc_flag, 6'b100000);
        chk(hi_out == 3'b001 && lo_out == 3'b010, "R4 phase 2 off", {hi_out, lo_out}, 6'b001010);
        cyc(1); node_above_lo[2] = 0;
        cyc(1); @(negedge clk);
        chk(hi_out == 3'b101 && lo_out == 3'b110, "R4 recovers on release", {hi_out, lo_out}, 6'b101110);
        chk(diag_n == 0, "R9 diag low until clear", diag_n, 0);
        cyc(1); lo_cmd = 3'b010; clear_all();

        // R6: all phases
        cur_req = "R6";
        cfg(3, 0); node_below_hi[0] = 1;
        cyc(8); @(negedge clk);
        chk(rel_out == 0 && hi_out == 0 && lo_out == 0, "R6 code 011 all off", rel_out, 0);
        cyc(1); node_below_hi[0] = 0;
        cyc(1); @(negedge clk);
        chk(rel_out == 5'h1f && hi_out == 3'b101, "R6 code 011 recovers", rel_out, 5'h1f);
        cyc(1); clear_all();
        cfg(4, 0); node_below_hi[0] = 1;
        cyc(8); node_below_hi[0] = 0;
        cyc(1); @(negedge clk);
        chk(rel_out == 0 && lo_out == 0, "R6 code 100 held off", rel_out, 0);
        cyc(1); clear_all(); @(negedge clk);
        chk(rel_out == 5'h1f, "R6 code 100 released by clear", rel_out, 5'h1f);

        // R7: charge pump
        cur_req = "R7";
        cyc(1); cfg(5, 0); node_below_hi[2] = 1;
        cyc(8); @(negedge clk); chk(cp_en == 0 && rel_out == 0, "R7 code 101 pump off", cp_en, 0);
        cyc(1); node_below_hi[2] = 0;
        cyc(1); @(negedge clk); chk(cp_en == 1, "R7 code 101 pump recovers", cp_en, 1);
        cyc(1); clear_all();
        cfg(6, 0); node_below_hi[2] = 1;
        cyc(8); node_below_hi[2] = 0;
        cyc(1); @(negedge clk); chk(cp_en == 0, "R7 code 110 pump held off", cp_en, 0);
        cyc(1); clear_all(); @(negedge clk); chk(cp_en == 1, "R7 code 110 pump back after clear", cp_en, 1);

        // R3: report only
        cur_req = "R3";
        cyc(1); cfg(0, 0); node_below_hi[0] = 1;
        cyc(8); @(negedge clk);
        chk(sc_flag[0] && hi_out == 3'b101 && rel_out == 5'h1f && diag_n == 0, "R3 no driver action, diag low",
            {hi_out, diag_n}, 4'b1010);
        cyc(1); node_below_hi[0] = 0;
        cyc(1); @(negedge clk); chk(diag_n == 0, "R3 diag stays low", diag_n, 0);
        cyc(1); clear_all(); @(negedge clk); chk(diag_n == 1, "R9 diag high after clear", diag_n, 1);

        // R12: code write during a fault is deferred
        cur_req = "R12";
        cyc(1); cfg(3, 0); node_below_hi[0] = 1;
        cyc(8); cfg(1, 0); @(negedge clk);
        chk(rel_out == 0, "R12 old code still active", rel_out, 0);
        cyc(1); node_below_hi[0] = 0;
        cyc(1); clear_all();
        node_below_hi[2] = 1;
        cyc(8); @(negedge clk);
        chk(rel_out == 5'h1f && hi_out == 3'b001, "R12 new code applies after clear", {rel_out, hi_out}, 8'hf9);
        cyc(1); node_below_hi[2] = 0;
        cyc(1); clear_all();

        // R11: suspended by external off
        cur_req = "R11";
        drv_off_ext = 1; node_below_hi[0] = 1;
        cyc(20); @(negedge clk); chk(sc_flag == 0 && sc_status == 0, "R11 no detection while drivers off", sc_flag, 0);
        cyc(1); drv_off_ext = 0;
        cyc(8); @(negedge clk); chk(sc_flag[0] == 1, "R11 detection resumes", sc_flag, 1);
        cyc(1); node_below_hi[0] = 0;
        cyc(1); clear_all();

        // R8: detection disabled
        cur_req = "R8";
        cfg(7, 0); node_below_hi[0] = 1; lo_cmd = 3'b111; node_above_lo = 3'b111;
        cyc(30); @(negedge clk);
        chk(sc_flag == 0 && sc_status == 0 && diag_n == 1, "R8 code 111 no detection", {sc_flag, sc_status}, 0);
        cyc(1); node_below_hi = 0; node_above_lo = 0; lo_cmd = 3'b010;

        // R2: remaining filter settings
        cur_req = "R2";
        for (int s = 1; s < 4; s++) begin
            cyc(1); cfg(1, s); node_below_hi[2] = 1;
            cyc(lim_of(s) - 1); @(negedge clk);
            chk(sc_flag == 0, "R2 not yet at limit", sc_flag, 0);
            cyc(1); @(negedge clk);
            chk(sc_flag == 6'b000100, "R2 flag at limit", sc_flag, 6'b000100);
            cyc(1); node_below_hi[2] = 0;
            cyc(1); clear_all();
        end

        cyc(4);
        summary();
    end
endmodule